// File: doc/BRIEF.md
# SDI Scrambling Serializer

This block turns a stream of 10-bit parallel video words into one serial bit stream for a serial digital video link. Each word is loaded on a word-rate enable pulse and shifted out one bit per bit-clock cycle, least significant bit first. The bit clock runs at ten times the word rate. Every serial bit passes through a self-synchronizing scrambler with the polynomial x^9 + x^4 + 1, and then through an NRZ-to-NRZI stage. The line then carries level changes rather than levels, so a receiver that descrambles the stream and decodes the changes gets the words back however the line polarity is set.

The parallel side takes either full 10-bit words or 8-bit words. In 8-bit mode the byte arrives on the upper eight data lines and the two lowest bits are forced. With sync detection enabled, an all-ones byte is promoted to the 10-bit all-ones code, so that timing reference sequences keep their full form on the link. A lock flag tells downstream logic when the serial output has begun. It stays low through reset and for one word period after it.

Top module: `sdi_serializer`

## Requirements
- R1: The scrambled bit is s(n) = d(n) XOR s(n-4) XOR s(n-9), where d is the serial data bit. The scrambler history is all zero after reset.
- R2: The output `sdo` is NRZI. A scrambled 1 inverts the level, a scrambled 0 keeps it, and the level is 0 after reset.
- R3: A word loaded at the clock edge where `word_en` is sampled high is sent LSB first. Bit i decides the `sdo` level that follows edge k+1+i, where k is the loading edge.
- R4: With `narrow_mode` = 0, all ten bits of `din` are sent unchanged, whatever `sync_det_dis` is. This includes 3FC.
- R5: With `narrow_mode` = 1, the sent word is {din[9:2], 2'b00}, and din[1:0] has no effect.
- R6: With `narrow_mode` = 1, `sync_det_dis` = 0 and din[9:2] = FF, the sent word is 3FF. With `sync_det_dis` = 1 the same input gives 3FC.
- R7: `locked` is low during reset and for the first ten clock edges after reset. It rises at the first `word_en` edge after that and stays high until the next reset.
- R8: A reset in mid-stream clears `sdo`, `locked` and all of the scrambler, NRZI and shift state at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, ten cycles per word |
| rst | input | 1 | Synchronous active-high reset |
| word_en | input | 1 | Word-rate enable, high for one clk cycle per word |
| din | input | 10 | Parallel data word; in 8-bit mode the byte sits on din[9:2] |
| narrow_mode | input | 1 | 1 selects 8-bit words, 0 selects 10-bit words |
| sync_det_dis | input | 1 | 1 disables all-ones sync detection in 8-bit mode |
| sdo | output | 1 | Scrambled NRZI serial output, registered |
| locked | output | 1 | Serial output valid flag, registered |

## Verification
The bound checker watches several rules on every cycle: the NRZI toggle rule against the scrambler output, the first bit leaving the shift register after each load in both word widths and in the sync-fill case, the clearing effect of reset, and the lock hold window together with the rule that lock never falls. The polynomial can only be seen in the bench's scenarios. There the bench compares the first word after reset with a hand-derived level sequence, then descrambles and NRZI-decodes the whole stream to recover every word of the vector table. The timing of the lock rise against the first qualifying word and recovery after a mid-stream reset are also left to the directed tests.

// File: rtl/sdi_ser_pkg.sv
`timescale 1ns/1ps
package sdi_ser_pkg;
  localparam int SDI_WORD_W   = 10;
  localparam int SDI_NARROW_W = 8;
  localparam int SDI_SCR_LEN  = 9;
  localparam int SDI_SCR_TAP  = 4;

  typedef enum logic {
    FMT_WIDE   = 1'b0,
    FMT_NARROW = 1'b1
  } word_fmt_e;
endpackage

// File: rtl/sdi_word_cond.sv
`timescale 1ns/1ps
module sdi_word_cond #(
  parameter int WORD_W   = 10,
  parameter int NARROW_W = 8
) (
  input  logic [WORD_W-1:0] din,
  input  logic              narrow_mode,
  input  logic              sync_det_dis,
  output logic [WORD_W-1:0] word_out
);
  import sdi_ser_pkg::*;

  generate
    if (NARROW_W < WORD_W) begin : g_narrow
      localparam int PAD_W = WORD_W - NARROW_W;
      logic [NARROW_W-1:0] upper;
      logic                sync_hit;
      logic [WORD_W-1:0]   narrow_word;

      always_comb begin
        upper       = din[WORD_W-1 -: NARROW_W];
        sync_hit    = (&upper) & ~sync_det_dis;
        narrow_word = {upper, {PAD_W{sync_hit}}};
        if (word_fmt_e'(narrow_mode) == FMT_NARROW) word_out = narrow_word;
        else                                        word_out = din;
      end
    end else begin : g_wide_only
      logic unused_ctl;
      always_comb begin
        unused_ctl = narrow_mode ^ sync_det_dis;
        word_out   = din;
      end
    end
  endgenerate
endmodule

// File: rtl/sdi_piso.sv
`timescale 1ns/1ps
module sdi_piso #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  output logic              ser_bit
);
  logic [WORD_W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst)       sreg <= '0;
    else if (load) sreg <= word_in;
    else           sreg <= {1'b0, sreg[WORD_W-1:1]};
  end

  assign ser_bit = sreg[0];
endmodule

// File: rtl/sdi_scram_nrzi.sv
`timescale 1ns/1ps
module sdi_scram_nrzi #(
  parameter int SCR_LEN = 9,
  parameter int SCR_TAP = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic data_bit,
  output logic scr_bit,
  output logic sdo
);
  logic [SCR_LEN-1:0] hist;
  logic               level;

  assign scr_bit = data_bit ^ hist[SCR_TAP-1] ^ hist[SCR_LEN-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      hist  <= '0;
      level <= 1'b0;
    end else begin
      hist  <= {hist[SCR_LEN-2:0], scr_bit};
      level <= level ^ scr_bit;
    end
  end

  assign sdo = level;
endmodule

// File: rtl/sdi_lock_gen.sv
`timescale 1ns/1ps
module sdi_lock_gen #(
  parameter int HOLD = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic word_en,
  output logic locked
);
  localparam int CW = $clog2(HOLD + 1);
  logic [CW-1:0] hold_cnt;
  logic          hold_done;

  assign hold_done = (hold_cnt == CW'(HOLD));

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cnt <= '0;
      locked   <= 1'b0;
    end else begin
      if (!hold_done) hold_cnt <= hold_cnt + 1'b1;
      if (word_en && hold_done) locked <= 1'b1;
    end
  end
endmodule

// File: rtl/sdi_serializer.sv
`timescale 1ns/1ps
module sdi_serializer #(
  parameter int WORD_W   = sdi_ser_pkg::SDI_WORD_W,
  parameter int NARROW_W = sdi_ser_pkg::SDI_NARROW_W,
  parameter int SCR_LEN  = sdi_ser_pkg::SDI_SCR_LEN,
  parameter int SCR_TAP  = sdi_ser_pkg::SDI_SCR_TAP
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_en,
  input  logic [WORD_W-1:0] din,
  input  logic              narrow_mode,
  input  logic              sync_det_dis,
  output logic              sdo,
  output logic              locked
);
  localparam int HOLD = WORD_W;

  logic [WORD_W-1:0] cond_word;
  logic              ser_bit;
  logic              scr_bit;

  sdi_word_cond #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_cond (
    .din          (din),
    .narrow_mode  (narrow_mode),
    .sync_det_dis (sync_det_dis),
    .word_out     (cond_word)
  );

  sdi_piso #(.WORD_W(WORD_W)) u_piso (
    .clk     (clk),
    .rst     (rst),
    .load    (word_en),
    .word_in (cond_word),
    .ser_bit (ser_bit)
  );

  sdi_scram_nrzi #(.SCR_LEN(SCR_LEN), .SCR_TAP(SCR_TAP)) u_scr (
    .clk      (clk),
    .rst      (rst),
    .data_bit (ser_bit),
    .scr_bit  (scr_bit),
    .sdo      (sdo)
  );

  sdi_lock_gen #(.HOLD(HOLD)) u_lock (
    .clk     (clk),
    .rst     (rst),
    .word_en (word_en),
    .locked  (locked)
  );
endmodule

// File: rtl/sdi_serializer_chk.sv
`timescale 1ns/1ps
module sdi_serializer_chk #(
  parameter int WORD_W   = 10,
  parameter int NARROW_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                word_en,
  input logic [NARROW_W-1:0] din_hi,
  input logic                din_lsb,
  input logic                narrow_mode,
  input logic                sync_det_dis,
  input logic                ser_bit,
  input logic                scr_bit,
  input logic                sdo,
  input logic                locked
);
  localparam int CW = $clog2(WORD_W + 1);
  logic [CW-1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != CW'(WORD_W)) since_rst <= since_rst + 1'b1;
  end

  // R2: NRZI level follows the scrambler output
  assert_nrzi_toggle_R2: assert property (@(posedge clk) disable iff (rst)
    scr_bit |=> (sdo != $past(sdo)));
  assert_nrzi_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !scr_bit |=> $stable(sdo));

  // R4: wide mode sends din[0] first
  assert_wide_first_bit_R4: assert property (@(posedge clk) disable iff (rst)
    (word_en && !narrow_mode) |=> (ser_bit == $past(din_lsb)));

  // R5: narrow mode clears the low bit unless a sync byte is filled
  assert_narrow_low_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (word_en && narrow_mode && (sync_det_dis || !(&din_hi))) |=> !ser_bit);

  // R6: all-ones byte with detection enabled becomes all-ones word
  assert_sync_fill_R6: assert property (@(posedge clk) disable iff (rst)
    (word_en && narrow_mode && !sync_det_dis && (&din_hi)) |=> ser_bit);

  // R7: lock held low for one word period, then never falls
  assert_lock_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (since_rst != CW'(WORD_W)) |-> !locked);
  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);

  // R8: reset clears the outputs
  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (!sdo && !locked));
endmodule

bind sdi_serializer sdi_serializer_chk #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .word_en      (word_en),
  .din_hi       (din[WORD_W-1 -: NARROW_W]),
  .din_lsb      (din[0]),
  .narrow_mode  (narrow_mode),
  .sync_det_dis (sync_det_dis),
  .ser_bit      (ser_bit),
  .scr_bit      (scr_bit),
  .sdo          (sdo),
  .locked       (locked)
);

// File: tb/sdi_serializer_bench.sv
`timescale 1ns/1ps
module sdi_serializer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 200000;
  localparam int NVEC       = 12;
  localparam int HLEN       = 512;

  // {narrow_mode, sync_det_dis, din, expected word}
  localparam logic [21:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 10'h3FF, 10'h3FF},
    {1'b0, 1'b0, 10'h000, 10'h000},
    {1'b0, 1'b0, 10'h2A5, 10'h2A5},
    {1'b0, 1'b0, 10'h3FC, 10'h3FC},
    {1'b0, 1'b1, 10'h155, 10'h155},
    {1'b1, 1'b0, 10'h3FF, 10'h3FF},
    {1'b1, 1'b0, 10'h3FC, 10'h3FF},
    {1'b1, 1'b1, 10'h3FF, 10'h3FC},
    {1'b1, 1'b0, 10'h003, 10'h000},
    {1'b1, 1'b0, 10'h16B, 10'h168},
    {1'b1, 1'b1, 10'h201, 10'h200},
    {1'b0, 1'b0, 10'h001, 10'h001}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       word_en = 1'b0;
  logic [9:0] din = '0;
  logic       narrow_mode = 1'b0;
  logic       sync_det_dis = 1'b0;
  logic       sdo;
  logic       locked;

  int  checks = 0;
  int  errors = 0;
  int  cyc = 0;
  bit  done = 1'b0;
  int  bitpos = 0;
  logic sdo_hist [HLEN];
  logic lock_hist [HLEN];
  logic dec_hist [HLEN];
  logic prev_lvl = 1'b0;
  logic [8:0] dl = '0;
  int  lpos [NVEC+2];

  sdi_serializer u_sdi_serializer (
    .clk(clk), .rst(rst), .word_en(word_en), .din(din),
    .narrow_mode(narrow_mode), .sync_det_dis(sync_det_dis),
    .sdo(sdo), .locked(locked)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_CYCLES && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog (R3) actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock edge, then sample and decode away from the edge
  task automatic step();
    logic nrz, d;
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (rst) begin
      prev_lvl = 1'b0; dl = '0; d = 1'b0;
    end else begin
      nrz = sdo ^ prev_lvl;
      d   = nrz ^ dl[3] ^ dl[8];
      dl  = {dl[7:0], nrz};
      prev_lvl = sdo;
    end
    sdo_hist[bitpos]  = sdo;
    lock_hist[bitpos] = locked;
    dec_hist[bitpos]  = d;
    bitpos++;
  endtask

  task automatic send_word(input logic [9:0] w, input logic nm, input logic sd, output int lp);
    din = w; narrow_mode = nm; sync_det_dis = sd; word_en = 1'b1;
    lp = bitpos;
    step();
    word_en = 1'b0;
    repeat (9) step();
  endtask

  function automatic logic [9:0] recovered(input int lp);
    logic [9:0] w;
    for (int i = 0; i < 10; i++) w[i] = dec_hist[lp + 1 + i];
    return w;
  endfunction

  function automatic logic [9:0] levels(input int lp);
    logic [9:0] w;
    for (int i = 0; i < 10; i++) w[i] = sdo_hist[lp + 1 + i];
    return w;
  endfunction

  initial begin
    int lp_tmp;
    repeat (3) step();
    chk("R8 reset sdo", {9'b0, sdo}, 10'h000);
    chk("R7 reset locked", {9'b0, locked}, 10'h000);
    rst = 1'b0;
    repeat (5) step();
    chk("R7 locked low in hold", {9'b0, locked}, 10'h000);

    // first word 0x001 from a clean scrambler: s = 1,0,0,0,1,0,0,0,1,1
    send_word(10'h001, 1'b0, 1'b0, lpos[0]);
    chk("R7 locked low before qualifying word", {9'b0, lock_hist[bitpos-1]}, 10'h000);

    for (int n = 0; n < NVEC; n++)
      send_word(VEC[n][19:10], VEC[n][21], VEC[n][20], lpos[n+1]);
    send_word(10'h000, 1'b0, 1'b0, lpos[NVEC+1]);

    chk("R1 R2 R3 NRZI levels of first word", levels(lpos[0]), 10'h10F);
    chk("R7 locked rises at second word", {9'b0, lock_hist[lpos[1]]}, 10'h001);
    chk("R7 locked stays high", {9'b0, lock_hist[bitpos-1]}, 10'h001);
    chk("R3 first word recovered", recovered(lpos[0]), 10'h001);

    for (int n = 0; n < NVEC; n++) begin
      string req;
      if (VEC[n][21] == 1'b0)                          req = "R4 wide word";
      else if (VEC[n][19:12] == 8'hFF)                 req = "R6 sync fill";
      else                                             req = "R5 narrow word";
      chk(req, recovered(lpos[n+1]), VEC[n][9:0]);
    end

    // mid-stream reset
    din = 10'h3A5; word_en = 1'b1; step(); word_en = 1'b0; step();
    rst = 1'b1;
    step();
    chk("R8 mid reset sdo", {9'b0, sdo}, 10'h000);
    chk("R8 mid reset locked", {9'b0, locked}, 10'h000);
    rst = 1'b0;
    repeat (3) step();
    chk("R7 locked low after reset", {9'b0, locked}, 10'h000);
    send_word(10'h001, 1'b0, 1'b0, lp_tmp);
    send_word(10'h000, 1'b0, 1'b0, lpos[0]);
    chk("R8 clean state after reset", levels(lp_tmp), 10'h10F);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule